// File: doc/BRIEF.md
# Descriptor Ring Fetch Engine

This block walks two descriptor rings held in host memory on behalf of an infrared link controller: one ring for received frames and one for frames to transmit. Each ring has its own index. From a page byte, a 1 KB-aligned ring base, the ring select and the index, the block builds the bus address of the current descriptor. It reads the descriptor with single-word bus cycles and keeps the fetched count and buffer pointer on chip. If the hardware owns the descriptor, the block passes the buffer address and byte count to the frame datapath with a one-cycle start pulse.

When the datapath reports completion, the block writes the final count and status back into the descriptor with the ownership bit cleared. It then advances the index modulo the ring size and tries the next descriptor straight away. A prompt pulse starts any idle ring. A ring that is busy with a descriptor ignores the prompt. Dropping the master enable stops both rings and returns both indices to zero. The two rings share one request/acknowledge bus port, with at most one transaction outstanding.

Top module: `irlink_ring_walker`

## Requirements
- R1: While reset is low or `master_en_i` is low, both ring indices read back as zero, both rings are idle and `bus_req_o` is low.
- R2: Every bus address is {page[7:0], base[13:0], ring (0 receive, 1 transmit), index[5:0], word, 2'b00}. Word 0 sits at byte offset 0 of the 8-byte descriptor and word 1 at byte offset 4. The receive ring therefore starts at the base and the transmit ring 512 bytes above it.
- R3: The ring size code is 4 bits: 0000 gives 4, 0001 gives 8, 0011 gives 16, 0111 gives 32 and 1111 gives 64 descriptors. The transmit code is `ring_size_i[15:12]` and the receive code is `ring_size_i[11:8]`. An index that advances past the last descriptor wraps to 0.
- R4: `ring_ptr_o` carries the receive index in bits [5:0] and the transmit index in bits [13:8]. Bits [7:6] and [15:14] are zero.
- R5: A fetch reads word 0 (count in bits [11:0]) and then word 1 (buffer pointer in [23:0], status in [31:24], ownership in bit 31). If bit 31 is clear, the ring goes idle with its index unchanged, issues no start and writes nothing.
- R6: For an owned descriptor, the ring's start output pulses for one cycle. The buffer address is {page, pointer[23:0]} and the count is the word 0 count.
- R7: On the ring's done pulse, the block writes word 0 = {20'b0, done count} and then word 1 = {1'b0, done status[6:0], pointer[23:0]}. It then advances the index and fetches the next descriptor.
- R8: A prompt makes an idle ring start fetching. A ring that holds an active descriptor ignores the prompt and makes no extra bus access.
- R9: When both rings request in the same cycle, the receive ring is served first. Only one transaction is outstanding at a time, and the request, write flag, address and write data stay unchanged until the acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| master_en_i | input | 1 | Run enable; low stops both rings and clears the indices |
| prompt_i | input | 1 | One-cycle pulse that starts idle rings |
| page_i | input | 8 | Address bits [31:24] for all bus accesses |
| ring_base_i | input | 14 | Address bits [23:10] of the ring area |
| ring_size_i | input | 16 | Size codes: transmit [15:12], receive [11:8] |
| ring_ptr_o | output | 16 | Index readback: receive [5:0], transmit [13:8] |
| bus_req_o | output | 1 | Bus transaction request |
| bus_we_o | output | 1 | 1 = write, 0 = read |
| bus_addr_o | output | 32 | Word address of the transaction |
| bus_wdata_o | output | 32 | Write data |
| bus_ack_i | input | 1 | Transaction complete (read data valid) |
| bus_rdata_i | input | 32 | Read data |
| rx_start_o | output | 1 | Receive descriptor handed to the datapath |
| rx_buf_addr_o | output | 32 | Receive buffer bus address |
| rx_count_o | output | 12 | Receive descriptor count |
| rx_done_i | input | 1 | Receive datapath finished |
| rx_done_count_i | input | 12 | Final receive byte count |
| rx_done_status_i | input | 7 | Receive status bits [6:0] |
| tx_start_o | output | 1 | Transmit descriptor handed to the datapath |
| tx_buf_addr_o | output | 32 | Transmit buffer bus address |
| tx_count_o | output | 12 | Transmit descriptor count |
| tx_done_i | input | 1 | Transmit datapath finished |
| tx_done_count_i | input | 12 | Final transmit count |
| tx_done_status_i | input | 7 | Transmit status bits [6:0] |

## Verification
A bus transaction is granted one cycle after the ring raises its request and completes on the edge where the acknowledge is seen. A start pulse therefore appears on the edge that takes in the acknowledge of the second read, and the bench samples it at the next falling edge, where the datapath models check the address and count. The write-backs and the index advance finish a known number of transactions after done. The bench waits a window sized from that per-descriptor cost before it compares the pointer readback and the memory image. It checks exact bus ordering from a logged access sequence, not from timing guesses.

// File: rtl/irw_pkg.sv
package irw_pkg;

    // Per-ring walker states, in the order a descriptor passes through them.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD_CNT,
        ST_RD_PTR,
        ST_BUSY,
        ST_WB_CNT,
        ST_WB_STAT
    } ring_state_e;

endpackage

// File: rtl/irw_ring_channel.sv
// irw_ring_channel
// Walks one descriptor ring: fetches the two words of the current
// descriptor, checks ownership, hands the buffer to the datapath, writes
// the result back with ownership released and advances the index.
// Assumes: the bus arbiter holds each command until it returns an ack,
// and configuration inputs stay stable while run_i is high.
module irw_ring_channel
    import irw_pkg::*;
#(
    parameter int PAGE_W = 8,
    parameter int BASE_W = 14,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 12,
    parameter int STAT_W = 7,
    parameter int BUF_W  = 24,
    parameter int DATA_W = 32,
    parameter bit IS_TX  = 1'b0
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           run_i,
    input  logic                           prompt_i,
    input  logic [PAGE_W-1:0]              page_i,
    input  logic [BASE_W-1:0]              base_i,
    input  logic [IDX_W-3:0]               size_code_i,
    output logic                           cmd_req_o,
    output logic                           cmd_we_o,
    output logic [PAGE_W+BASE_W+IDX_W+3:0] cmd_addr_o,
    output logic [DATA_W-1:0]              cmd_wdata_o,
    input  logic                           cmd_ack_i,
    input  logic [DATA_W-1:0]              rdata_i,
    output logic                           start_o,
    output logic [PAGE_W+BUF_W-1:0]        buf_addr_o,
    output logic [CNT_W-1:0]               count_o,
    input  logic                           done_i,
    input  logic [CNT_W-1:0]               done_count_i,
    input  logic [STAT_W-1:0]              done_status_i,
    output logic [IDX_W-1:0]               idx_o
);

    localparam int OWN_BIT = DATA_W - 1;

    ring_state_e        state_q;
    logic [IDX_W-1:0]   idx_q;
    logic [IDX_W-1:0]   idx_mask;
    logic               start_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [BUF_W-1:0]   buf_q;
    logic [CNT_W-1:0]   wb_cnt_q;
    logic [STAT_W-1:0]  wb_stat_q;
    logic               word_sel;
    logic               unused_rdata;

    // Thermometer size code widened by the two always-set low bits gives the wrap mask.
    assign idx_mask = {size_code_i, 2'b11};

    // Status byte bits other than ownership are not used on a fetch.
    assign unused_rdata = ^rdata_i[DATA_W-2:BUF_W];

    // Descriptor walk: fetch, hand off, write back, advance.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            start_q   <= 1'b0;
            cnt_q     <= '0;
            buf_q     <= '0;
            wb_cnt_q  <= '0;
            wb_stat_q <= '0;
        end else begin
            start_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (prompt_i) begin
                        state_q <= ST_RD_CNT;
                    end
                end
                ST_RD_CNT: begin
                    if (cmd_ack_i) begin
                        cnt_q   <= rdata_i[CNT_W-1:0];
                        state_q <= ST_RD_PTR;
                    end
                end
                ST_RD_PTR: begin
                    if (cmd_ack_i) begin
                        if (rdata_i[OWN_BIT]) begin
                            buf_q   <= rdata_i[BUF_W-1:0];
                            start_q <= 1'b1;
                            state_q <= ST_BUSY;
                        end else begin
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_BUSY: begin
                    if (done_i) begin
                        wb_cnt_q  <= done_count_i;
                        wb_stat_q <= done_status_i;
                        state_q   <= ST_WB_CNT;
                    end
                end
                ST_WB_CNT: begin
                    if (cmd_ack_i) begin
                        state_q <= ST_WB_STAT;
                    end
                end
                ST_WB_STAT: begin
                    if (cmd_ack_i) begin
                        idx_q   <= (idx_q + 1'b1) & idx_mask;
                        state_q <= ST_RD_CNT;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Bus command for the current state: which word, read or write, what data.
    always_comb begin
        cmd_req_o   = 1'b0;
        cmd_we_o    = 1'b0;
        word_sel    = 1'b0;
        cmd_wdata_o = '0;
        case (state_q)
            ST_RD_CNT: begin
                cmd_req_o = 1'b1;
            end
            ST_RD_PTR: begin
                cmd_req_o = 1'b1;
                word_sel  = 1'b1;
            end
            ST_WB_CNT: begin
                cmd_req_o   = 1'b1;
                cmd_we_o    = 1'b1;
                cmd_wdata_o = {{(DATA_W-CNT_W){1'b0}}, wb_cnt_q};
            end
            ST_WB_STAT: begin
                cmd_req_o   = 1'b1;
                cmd_we_o    = 1'b1;
                word_sel    = 1'b1;
                cmd_wdata_o = {1'b0, wb_stat_q, buf_q};
            end
            default: ;
        endcase
    end

    // Descriptor address is a pure concatenation thanks to the aligned base.
    assign cmd_addr_o = {page_i, base_i, IS_TX, idx_q, word_sel, 2'b00};
    assign start_o    = start_q;
    assign buf_addr_o = {page_i, buf_q};
    assign count_o    = cnt_q;
    assign idx_o      = idx_q;

    p_disable_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (idx_q == '0 && state_q == ST_IDLE));

    p_unowned_keeps_idx_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && state_q == ST_RD_PTR && cmd_ack_i && !rdata_i[OWN_BIT])
        |=> (state_q == ST_IDLE && $stable(idx_q) && !start_o));

    p_start_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);

    p_busy_ignores_prompt_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && state_q == ST_BUSY && !done_i) |=> (state_q == ST_BUSY && !cmd_req_o));

endmodule

// File: rtl/irw_bus_arbiter.sv
// irw_bus_arbiter
// Shares one request/acknowledge word port between the two ring walkers.
// The receive walker wins when both ask in the same cycle; a granted
// command is held until the bus acknowledges it, one at a time.
// Assumes: each walker keeps its command stable until its own ack.
module irw_bus_arbiter #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              rx_req_i,
    input  logic              rx_we_i,
    input  logic [ADDR_W-1:0] rx_addr_i,
    input  logic [DATA_W-1:0] rx_wdata_i,
    output logic              rx_ack_o,
    input  logic              tx_req_i,
    input  logic              tx_we_i,
    input  logic [ADDR_W-1:0] tx_addr_i,
    input  logic [DATA_W-1:0] tx_wdata_i,
    output logic              tx_ack_o,
    output logic              bus_req_o,
    output logic              bus_we_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    input  logic              bus_ack_i
);

    logic busy_q;
    logic own_tx_q;

    // Grant tracking: pick an owner when idle, release it on the ack.
    always_ff @(posedge clk) begin
        if (!rst_n || !run_i) begin
            busy_q   <= 1'b0;
            own_tx_q <= 1'b0;
        end else if (busy_q) begin
            if (bus_ack_i) begin
                busy_q <= 1'b0;
            end
        end else if (rx_req_i) begin
            busy_q   <= 1'b1;
            own_tx_q <= 1'b0;
        end else if (tx_req_i) begin
            busy_q   <= 1'b1;
            own_tx_q <= 1'b1;
        end
    end

    // Steer the owner's command to the port and the ack back to the owner.
    always_comb begin
        bus_req_o   = busy_q;
        bus_we_o    = own_tx_q ? tx_we_i    : rx_we_i;
        bus_addr_o  = own_tx_q ? tx_addr_i  : rx_addr_i;
        bus_wdata_o = own_tx_q ? tx_wdata_i : rx_wdata_i;
        rx_ack_o    = busy_q && !own_tx_q && bus_ack_i;
        tx_ack_o    = busy_q &&  own_tx_q && bus_ack_i;
    end

    p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && bus_req_o && !bus_ack_i)
        |=> (bus_req_o && $stable(bus_we_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)));

    p_rx_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !bus_req_o && rx_req_i && tx_req_i)
        |=> (bus_req_o && bus_addr_o == $past(rx_addr_i)));

    p_single_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rx_ack_o, tx_ack_o}));

endmodule

// File: rtl/irlink_ring_walker.sv
// irlink_ring_walker
// Top of the descriptor ring engine: one walker per ring (receive, then
// transmit), a shared bus arbiter, size-code extraction and pointer readback.
// Assumes: page, base and size inputs change only while master enable is low.
module irlink_ring_walker #(
    parameter int PAGE_W = 8,
    parameter int BASE_W = 14,
    parameter int IDX_W  = 6,
    parameter int CNT_W  = 12,
    parameter int STAT_W = 7,
    parameter int BUF_W  = 24,
    parameter int DATA_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           master_en_i,
    input  logic                           prompt_i,
    input  logic [PAGE_W-1:0]              page_i,
    input  logic [BASE_W-1:0]              ring_base_i,
    input  logic [4*(IDX_W-2)-1:0]         ring_size_i,
    output logic [2*IDX_W+3:0]             ring_ptr_o,
    output logic                           bus_req_o,
    output logic                           bus_we_o,
    output logic [PAGE_W+BASE_W+IDX_W+3:0] bus_addr_o,
    output logic [DATA_W-1:0]              bus_wdata_o,
    input  logic                           bus_ack_i,
    input  logic [DATA_W-1:0]              bus_rdata_i,
    output logic                           rx_start_o,
    output logic [PAGE_W+BUF_W-1:0]        rx_buf_addr_o,
    output logic [CNT_W-1:0]               rx_count_o,
    input  logic                           rx_done_i,
    input  logic [CNT_W-1:0]               rx_done_count_i,
    input  logic [STAT_W-1:0]              rx_done_status_i,
    output logic                           tx_start_o,
    output logic [PAGE_W+BUF_W-1:0]        tx_buf_addr_o,
    output logic [CNT_W-1:0]               tx_count_o,
    input  logic                           tx_done_i,
    input  logic [CNT_W-1:0]               tx_done_count_i,
    input  logic [STAT_W-1:0]              tx_done_status_i
);

    localparam int SZ_W    = IDX_W - 2;
    localparam int ADDR_W  = PAGE_W + BASE_W + IDX_W + 4;
    localparam int N_RINGS = 2;
    localparam int HI_W    = PAGE_W + BASE_W;

    logic [SZ_W-1:0]   sz_code  [N_RINGS];
    logic              ch_req   [N_RINGS];
    logic              ch_we    [N_RINGS];
    logic [ADDR_W-1:0] ch_addr  [N_RINGS];
    logic [DATA_W-1:0] ch_wdata [N_RINGS];
    logic              ch_ack   [N_RINGS];
    logic              ch_start [N_RINGS];
    logic [PAGE_W+BUF_W-1:0] ch_buf [N_RINGS];
    logic [CNT_W-1:0]  ch_cnt   [N_RINGS];
    logic              ch_done  [N_RINGS];
    logic [CNT_W-1:0]  ch_dcnt  [N_RINGS];
    logic [STAT_W-1:0] ch_dstat [N_RINGS];
    logic [IDX_W-1:0]  ch_idx   [N_RINGS];
    logic              unused_size_low;

    // Size codes sit in the upper half of the size word; the lower half is spare.
    assign sz_code[0]      = ring_size_i[2*SZ_W +: SZ_W];
    assign sz_code[1]      = ring_size_i[3*SZ_W +: SZ_W];
    assign unused_size_low = ^ring_size_i[2*SZ_W-1:0];

    assign ch_done[0]  = rx_done_i;
    assign ch_dcnt[0]  = rx_done_count_i;
    assign ch_dstat[0] = rx_done_status_i;
    assign ch_done[1]  = tx_done_i;
    assign ch_dcnt[1]  = tx_done_count_i;
    assign ch_dstat[1] = tx_done_status_i;

    // One walker per ring; index 0 is receive, index 1 is transmit.
    for (genvar g = 0; g < N_RINGS; g++) begin : g_ring
        irw_ring_channel #(
            .PAGE_W (PAGE_W),
            .BASE_W (BASE_W),
            .IDX_W  (IDX_W),
            .CNT_W  (CNT_W),
            .STAT_W (STAT_W),
            .BUF_W  (BUF_W),
            .DATA_W (DATA_W),
            .IS_TX  (g == 1)
        ) u_chan (
            .clk           (clk),
            .rst_n         (rst_n),
            .run_i         (master_en_i),
            .prompt_i      (prompt_i),
            .page_i        (page_i),
            .base_i        (ring_base_i),
            .size_code_i   (sz_code[g]),
            .cmd_req_o     (ch_req[g]),
            .cmd_we_o      (ch_we[g]),
            .cmd_addr_o    (ch_addr[g]),
            .cmd_wdata_o   (ch_wdata[g]),
            .cmd_ack_i     (ch_ack[g]),
            .rdata_i       (bus_rdata_i),
            .start_o       (ch_start[g]),
            .buf_addr_o    (ch_buf[g]),
            .count_o       (ch_cnt[g]),
            .done_i        (ch_done[g]),
            .done_count_i  (ch_dcnt[g]),
            .done_status_i (ch_dstat[g]),
            .idx_o         (ch_idx[g])
        );
    end

    irw_bus_arbiter #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_arb (
        .clk         (clk),
        .rst_n       (rst_n),
        .run_i       (master_en_i),
        .rx_req_i    (ch_req[0]),
        .rx_we_i     (ch_we[0]),
        .rx_addr_i   (ch_addr[0]),
        .rx_wdata_i  (ch_wdata[0]),
        .rx_ack_o    (ch_ack[0]),
        .tx_req_i    (ch_req[1]),
        .tx_we_i     (ch_we[1]),
        .tx_addr_i   (ch_addr[1]),
        .tx_wdata_i  (ch_wdata[1]),
        .tx_ack_o    (ch_ack[1]),
        .bus_req_o   (bus_req_o),
        .bus_we_o    (bus_we_o),
        .bus_addr_o  (bus_addr_o),
        .bus_wdata_o (bus_wdata_o),
        .bus_ack_i   (bus_ack_i)
    );

    // Readback and datapath hand-off ports.
    assign ring_ptr_o    = {2'b00, ch_idx[1], 2'b00, ch_idx[0]};
    assign rx_start_o    = ch_start[0];
    assign rx_buf_addr_o = ch_buf[0];
    assign rx_count_o    = ch_cnt[0];
    assign tx_start_o    = ch_start[1];
    assign tx_buf_addr_o = ch_buf[1];
    assign tx_count_o    = ch_cnt[1];

    p_page_base_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req_o |-> (bus_addr_o[ADDR_W-1 -: HI_W] == {page_i, ring_base_i}));

    p_release_owner_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req_o && bus_we_o && bus_addr_o[2]) |-> !bus_wdata_o[DATA_W-1]);

    p_idle_when_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !master_en_i |=> (!bus_req_o && ring_ptr_o == '0));

endmodule

// File: tb/irlink_ring_walker_tb.sv
module irlink_ring_walker_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        master_en = 1'b0;
    logic        prompt = 1'b0;
    logic [7:0]  page = 8'hA7;
    logic [13:0] base = 14'h2B5;
    logic [15:0] ring_size = 16'h0000;
    logic [15:0] ring_ptr;
    logic        bus_req, bus_we, bus_ack;
    logic [31:0] bus_addr, bus_wdata, bus_rdata;
    logic        rx_start, tx_start;
    logic [31:0] rx_buf, tx_buf;
    logic [11:0] rx_cnt, tx_cnt;

    logic        dp_done   [2];
    logic [11:0] dp_dcnt   [2];
    logic [6:0]  dp_dstat  [2];
    logic        dp_start_w[2];
    logic [31:0] dp_buf_w  [2];
    logic [11:0] dp_cnt_w  [2];

    logic [31:0] mem [256];
    int          exp_idx   [2];
    int          start_cnt [2];
    int          cur_size  [2];
    int          dp_delay  [2];
    int          acc_cnt   [2];
    logic [31:0] acc_log   [3];
    int          log_n = 3;
    logic [7:0]  seed = 8'h11;
    int          checks = 0;
    int          failures = 0;
    bit          finished = 1'b0;

    always #4 clk = ~clk;

    irlink_ring_walker dut_i (
        .clk              (clk),
        .rst_n            (rst_n),
        .master_en_i      (master_en),
        .prompt_i         (prompt),
        .page_i           (page),
        .ring_base_i      (base),
        .ring_size_i      (ring_size),
        .ring_ptr_o       (ring_ptr),
        .bus_req_o        (bus_req),
        .bus_we_o         (bus_we),
        .bus_addr_o       (bus_addr),
        .bus_wdata_o      (bus_wdata),
        .bus_ack_i        (bus_ack),
        .bus_rdata_i      (bus_rdata),
        .rx_start_o       (rx_start),
        .rx_buf_addr_o    (rx_buf),
        .rx_count_o       (rx_cnt),
        .rx_done_i        (dp_done[0]),
        .rx_done_count_i  (dp_dcnt[0]),
        .rx_done_status_i (dp_dstat[0]),
        .tx_start_o       (tx_start),
        .tx_buf_addr_o    (tx_buf),
        .tx_count_o       (tx_cnt),
        .tx_done_i        (dp_done[1]),
        .tx_done_count_i  (dp_dcnt[1]),
        .tx_done_status_i (dp_dstat[1])
    );

    assign dp_start_w[0] = rx_start;
    assign dp_start_w[1] = tx_start;
    assign dp_buf_w[0]   = rx_buf;
    assign dp_buf_w[1]   = tx_buf;
    assign dp_cnt_w[0]   = rx_cnt;
    assign dp_cnt_w[1]   = tx_cnt;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] f_buf(int r, int i);
        return {4'h3, 3'b000, r[0], 2'b00, i[5:0], seed};
    endfunction

    function automatic logic [11:0] f_cnt(int r, int i);
        return 12'(12'h040 + i * 5 + r * 7 + int'(seed));
    endfunction

    function automatic logic [31:0] desc_addr(int r, int i, int w);
        return {page, base, r[0], i[5:0], w[0], 2'b00};
    endfunction

    // Bus slave: one-cycle ack at the falling edge after a request is seen.
    initial begin
        bus_ack = 1'b0;
        bus_rdata = '0;
        forever begin
            @(negedge clk);
            if (bus_ack) begin
                bus_ack = 1'b0;
            end else if (bus_req) begin
                chk(bus_addr[31:10] == {page, base}, "R2", "page/base bits",
                    {10'b0, bus_addr[31:10]}, {10'b0, page, base});
                if (bus_we) mem[bus_addr[9:2]] = bus_wdata;
                else        bus_rdata = mem[bus_addr[9:2]];
                acc_cnt[bus_addr[9]]++;
                if (log_n < 3) begin
                    acc_log[log_n] = bus_addr;
                    log_n++;
                end
                bus_ack = 1'b1;
            end
        end
    end

    // Datapath models: check each hand-off, then report done after a delay.
    for (genvar g = 0; g < 2; g++) begin : g_dp
        initial begin
            dp_done[g]  = 1'b0;
            dp_dcnt[g]  = '0;
            dp_dstat[g] = '0;
            forever begin
                @(negedge clk);
                if (dp_start_w[g]) begin
                    int i;
                    logic [11:0] c;
                    i = exp_idx[g];
                    c = dp_cnt_w[g];
                    chk(dp_buf_w[g] == {page, f_buf(g, i)}, "R6", "start buffer address",
                        dp_buf_w[g], {page, f_buf(g, i)});
                    chk(c == f_cnt(g, i), "R6", "start count", {20'b0, c}, {20'b0, f_cnt(g, i)});
                    start_cnt[g]++;
                    exp_idx[g] = (i + 1) % cur_size[g];
                    repeat (dp_delay[g]) @(negedge clk);
                    dp_dcnt[g]  = c ^ 12'hA5A;
                    dp_dstat[g] = {1'(g), i[5:0]};
                    dp_done[g]  = 1'b1;
                    @(negedge clk);
                    dp_done[g]  = 1'b0;
                end
            end
        end
    end

    task automatic fill_ring(input int r, input int code, input int n);
        int sz;
        sz = (code + 1) * 4;
        cur_size[r] = sz;
        for (int i = 0; i < sz; i++) begin
            mem[{r[0], i[5:0], 1'b0}] = {20'b0, f_cnt(r, i)};
            mem[{r[0], i[5:0], 1'b1}] = {(i < n), 7'h00, f_buf(r, i)};
        end
    endtask

    // Stop the engine, lay out both rings and restart it (no prompt yet).
    task automatic prep(input int crx, input int nrx, input int ctx, input int ntx);
        @(negedge clk);
        master_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(ring_ptr == 16'h0000, "R1", "pointers cleared by disable", {16'b0, ring_ptr}, 32'h0);
        chk(bus_req == 1'b0, "R1", "no request while disabled", {31'b0, bus_req}, 32'h0);
        for (int k = 0; k < 256; k++) mem[k] = '0;
        seed = seed + 8'h1D;
        ring_size = {ctx[3:0], crx[3:0], 8'h00};
        fill_ring(0, crx, nrx);
        fill_ring(1, ctx, ntx);
        for (int r = 0; r < 2; r++) begin
            exp_idx[r] = 0;
            start_cnt[r] = 0;
            acc_cnt[r] = 0;
        end
        master_en = 1'b1;
        @(negedge clk);
    endtask

    task automatic pulse_prompt();
        prompt = 1'b1;
        @(negedge clk);
        prompt = 1'b0;
    endtask

    // After a run: hand-off count, pointer field, write-backs and untouched entries.
    task automatic check_ring(input int r, input int n);
        int sz;
        logic [5:0] fld;
        sz = cur_size[r];
        fld = (r == 0) ? ring_ptr[5:0] : ring_ptr[13:8];
        chk(start_cnt[r] == n, "R6", "number of hand-offs", start_cnt[r], n);
        chk(fld == 6'(n % sz), "R3", "index after wrap modulo size", {26'b0, fld}, n % sz);
        for (int i = 0; i < sz; i++) begin
            logic [31:0] w0, w1;
            w0 = mem[{r[0], i[5:0], 1'b0}];
            w1 = mem[{r[0], i[5:0], 1'b1}];
            if (i < n) begin
                chk(w0 == {20'b0, f_cnt(r, i) ^ 12'hA5A}, "R7", "count write-back",
                    w0, {20'b0, f_cnt(r, i) ^ 12'hA5A});
                chk(w1 == {1'b0, r[0], i[5:0], f_buf(r, i)}, "R7", "status write-back",
                    w1, {1'b0, r[0], i[5:0], f_buf(r, i)});
            end else begin
                chk(w1 == {8'h00, f_buf(r, i)} && w0 == {20'b0, f_cnt(r, i)}, "R5",
                    "unowned descriptor untouched", w1, {8'h00, f_buf(r, i)});
            end
        end
    endtask

    initial begin
        for (int r = 0; r < 2; r++) begin
            exp_idx[r] = 0; start_cnt[r] = 0; cur_size[r] = 4; dp_delay[r] = 3; acc_cnt[r] = 0;
        end
        master_en = 1'b1;
        repeat (4) @(negedge clk);
        // R1: reset state, even with enable high.
        chk(ring_ptr == 16'h0000, "R1", "pointers in reset", {16'b0, ring_ptr}, 32'h0);
        chk(!bus_req && !rx_start && !tx_start, "R1", "quiet outputs in reset",
            {29'b0, bus_req, rx_start, tx_start}, 32'h0);
        rst_n = 1'b1;

        // R5: nothing owned: two reads per ring, no hand-off, index stays.
        prep(0, 0, 0, 0);
        pulse_prompt();
        repeat (30) @(negedge clk);
        chk(acc_cnt[0] == 2 && acc_cnt[1] == 2, "R5", "two reads per ring",
            acc_cnt[0] * 16 + acc_cnt[1], 32'h22);
        chk(ring_ptr == 16'h0000, "R5", "index unchanged when unowned", {16'b0, ring_ptr}, 32'h0);
        chk(start_cnt[0] + start_cnt[1] == 0, "R5", "no hand-off", start_cnt[0] + start_cnt[1], 0);

        // R9 and R2: simultaneous prompt, receive first, exact address order.
        prep(0, 1, 0, 1);
        log_n = 0;
        pulse_prompt();
        repeat (60) @(negedge clk);
        chk(acc_log[0] == desc_addr(0, 0, 0), "R9", "first access is receive word 0",
            acc_log[0], desc_addr(0, 0, 0));
        chk(acc_log[1] == desc_addr(0, 0, 1), "R2", "second access is receive word 1",
            acc_log[1], desc_addr(0, 0, 1));
        chk(acc_log[2] == desc_addr(1, 0, 0), "R9", "third access is transmit word 0",
            acc_log[2], desc_addr(1, 0, 0));
        chk(ring_ptr == 16'h0101, "R4", "pointer fields after one descriptor each",
            {16'b0, ring_ptr}, 32'h0101);
        check_ring(0, 1);
        check_ring(1, 1);

        // R8: a busy ring ignores a second prompt.
        dp_delay[0] = 60;
        prep(0, 1, 0, 0);
        pulse_prompt();
        repeat (20) @(negedge clk);
        chk(start_cnt[0] == 1 && acc_cnt[0] == 2, "R8", "receive ring busy after fetch",
            start_cnt[0] * 16 + acc_cnt[0], 32'h12);
        pulse_prompt();
        repeat (20) @(negedge clk);
        chk(start_cnt[0] == 1 && acc_cnt[0] == 2, "R8", "prompt ignored while busy",
            start_cnt[0] * 16 + acc_cnt[0], 32'h12);
        repeat (100) @(negedge clk);
        chk(acc_cnt[0] == 6, "R7", "write-back then next fetch", acc_cnt[0], 6);
        check_ring(0, 1);
        dp_delay[0] = 3;

        // R3: sweep every size code on both rings with the whole ring owned.
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 5; c++) begin
                int code;
                int sz;
                code = (1 << c) - 1;
                sz = (code + 1) * 4;
                if (r == 0) prep(code, sz, 0, 0);
                else        prep(0, 0, code, sz);
                pulse_prompt();
                repeat (sz * 24 + 40) @(negedge clk);
                check_ring(r, sz);
            end
        end

        // R4: partial runs on both rings at once give exact pointer fields.
        prep(1, 3, 3, 5);
        pulse_prompt();
        repeat (300) @(negedge clk);
        chk(ring_ptr == 16'h0503, "R4", "pointer readback layout", {16'b0, ring_ptr}, 32'h0503);
        check_ring(0, 3);
        check_ring(1, 5);

        // R8: an idle ring resumes from its current index on a new prompt.
        mem[{1'b0, 6'd3, 1'b1}] = {1'b1, 7'h00, f_buf(0, 3)};
        pulse_prompt();
        repeat (80) @(negedge clk);
        chk(start_cnt[0] == 4, "R8", "idle ring restarts at index 3", start_cnt[0], 4);
        chk(ring_ptr == 16'h0504, "R4", "pointer after resume", {16'b0, ring_ptr}, 32'h0504);

        // R1: disabling mid-run clears everything.
        @(negedge clk);
        master_en = 1'b0;
        repeat (2) @(negedge clk);
        chk(ring_ptr == 16'h0000 && !bus_req, "R1", "disable clears pointers",
            {15'b0, bus_req, ring_ptr}, 32'h0);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog R1 act=%h exp=%h", 32'h0, 32'h1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule